// File: doc/BRIEF.md
# Receive FIFO with Hysteretic Auto-RTS

This block buffers received characters for a serial receiver. Each entry holds a data byte and its three error tags (parity, framing, break, for example). The entry at the head is shown on the read side together with its tags. The block also drives the active-low request-to-send pin. Under automatic control that pin throttles the far-end transmitter. The pin is released (driven high) once the fill level climbs to the trigger step just above the programmed one. It is driven low again only after the FIFO drains to the step just below the programmed one. This hysteresis stops the pin from chattering around a single threshold.

Both data sides use valid/ready. The write side is fed by receive logic that cannot stall. For that reason `wr_ready` only reports that space is left. A character presented while `wr_ready` is low is dropped, and a sticky overrun flag is set. The read side shows the head entry whenever `rd_valid` is high. The host takes that entry by raising `rd_ready` for one cycle. Raising `rd_ready` while `rd_valid` is low takes nothing, and the last data taken stays on the outputs.

The trigger select codes are 0, 1, 2 and 3. They program levels of 8, 16, 24 and 28 entries. Each level has an upper step and a lower step:

| Code | Programmed level | Upper step (pin released) | Lower step (pin driven low) |
|------|------------------|---------------------------|-----------------------------|
| 0    | 8                | 16                        | 0                           |
| 1    | 16               | 24                        | 8                           |
| 2    | 24               | 28                        | 16                          |
| 3    | 28               | 32                        | 24                          |

Top module: `rx_rts_fifo`

## Requirements
- R1: Entries leave in the order they were accepted. `rd_data` and `rd_err` show the 8-bit byte and 3-bit tag of the head entry whenever `rd_valid` is high. `rd_valid` is high exactly when `level` is nonzero.
- R2: `wr_ready` is high while `level` is below 32. A cycle with `wr_valid` and `wr_ready` both high stores one entry, and `level` rises by one after that clock edge. After reset, `level` is 0, `rd_valid` is 0, `wr_ready` is 1 and `overrun` is 0.
- R3: A write presented while the FIFO is full is dropped, and `level` stays at 32. `overrun` goes high after that edge and stays high until a cycle with `stat_rd` high. If a new overrun arrives in the same cycle as `stat_rd`, the overrun wins.
- R4: A cycle that both stores and takes an entry leaves `level` unchanged.
- R5: Raising `rd_ready` while the FIFO is empty leaves `level` at 0. `rd_data` and `rd_err` keep showing the last entry taken.
- R6: While automatic control is not armed, `rts_n` is the inverse of `rts_start`.
- R7: Automatic control arms on the clock edge after `rts_start` rises while `auto_rts_en` is 1. Arming leaves `rts_n` low. If `rts_start` is already 1 when `auto_rts_en` is set, the block does not arm, and `rts_n` keeps following R6. Clearing either input disarms.
- R8: While armed, `rts_n` goes high one cycle after `level` reaches the upper step of `trig_sel`. It does not go high at the programmed level.
- R9: Once released, `rts_n` stays high as `level` falls through the levels between the two steps. It goes low one cycle after `level` falls to the lower step or below.
- R10: When `rts_n` goes high under armed control and both `rts_irq_en` and `enh_en` are 1, `rts_irq` goes high on the same edge. It stays high until a cycle with `irq_clr` high or until armed control drives `rts_n` low again.
- R11: With code 3, `rts_n` is released only when the FIFO is full (32). With code 0, `rts_n` goes low again only when the FIFO is empty (0).
- R12: Writes continue to be accepted after `rts_n` goes high, until the FIFO holds 32 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A received character is presented |
| wr_ready | output | 1 | Space available; a write while low is dropped |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Error tags for the received byte |
| rd_ready | input | 1 | Host takes the head entry |
| rd_valid | output | 1 | FIFO is not empty |
| rd_data | output | 8 | Head byte, or the last byte taken when empty |
| rd_err | output | 3 | Head error tags, or the last tags taken when empty |
| level | output | 6 | Number of stored entries (0 to 32) |
| overrun | output | 1 | Sticky flag: a write was dropped |
| stat_rd | input | 1 | Status read; clears `overrun` |
| trig_sel | input | 2 | Trigger code (0 to 3 selects 8, 16, 24, 28) |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| rts_start | input | 1 | Software RTS bit; its rise arms automatic control |
| rts_irq_en | input | 1 | RTS interrupt enable |
| enh_en | input | 1 | Enhanced-function enable, needed for the interrupt |
| irq_clr | input | 1 | Clears `rts_irq` |
| rts_n | output | 1 | Active-low request-to-send pin |
| rts_irq | output | 1 | RTS release interrupt flag |

## Verification
The bench walks the fill level across each step, one entry at a time. A design with one shared threshold would release at the programmed level, or drive the pin low right after dropping below the upper step. The bench also arms with `rts_start` already set. A design that armed on the level of `rts_start` instead of on its rise would release the pin during that fill. It writes into a full FIFO, reads an empty one and does a simultaneous read and write. A wrong design would then wrap the pointers, lose or duplicate entries, or change the level. Codes 3 and 0 are run through full and empty. An off-by-one in the step table shows up there as a release at 31 or a low drive at 1.

// File: rtl/rx_rts_pkg.sv
package rx_rts_pkg;

  // Upper hysteresis step for a trigger code: where RTS# is released.
  function automatic int unsigned upper_step(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return (3 * depth) / 4;
      2'd2:    return (7 * depth) / 8;
      default: return depth;
    endcase
  endfunction

  // Lower hysteresis step for a trigger code: where RTS# is driven low again.
  function automatic int unsigned lower_step(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 0;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return (3 * depth) / 4;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH = 32,
  parameter int ENT_W = 11,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [ENT_W-1:0] wr_entry,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [ENT_W-1:0] rd_entry,
  output logic [LVL_W-1:0] level,
  input  logic             stat_rd,
  output logic             overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [ENT_W-1:0] last_q;
  logic             full, empty, push, pop;

  assign full     = (level == FULL_LVL);
  assign empty    = (level == '0);
  assign push     = wr_valid && !full;
  assign pop      = rd_ready && !empty;
  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign rd_entry = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      last_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_valid && full) overrun <= 1'b1;
      else if (stat_rd)     overrun <= 1'b0;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !rd_ready) |=> (level == FULL_LVL) && overrun);
  p_simul_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_valid && rd_ready) |=> (level == '0) && $stable(rd_entry));
endmodule

// File: rtl/rts_flow_ctl.sv
module rts_flow_ctl
  import rx_rts_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       trig_sel,
  input  logic             auto_rts_en,
  input  logic             rts_start,
  input  logic             rts_irq_en,
  input  logic             enh_en,
  input  logic             irq_clr,
  output logic             rts_n,
  output logic             rts_irq
);
  logic        start_q, armed_q, hold_q, hold_d, armed_d;
  logic        irq_set, irq_drop;
  int unsigned hi_lvl, lo_lvl, cur_lvl;

  assign hi_lvl  = upper_step(trig_sel, DEPTH);
  assign lo_lvl  = lower_step(trig_sel, DEPTH);
  assign cur_lvl = 32'(level);

  always_comb begin
    if (!auto_rts_en || !rts_start) armed_d = 1'b0;
    else if (!start_q)              armed_d = 1'b1;
    else                            armed_d = armed_q;

    if (!armed_q)    hold_d = 1'b0;
    else if (hold_q) hold_d = (cur_lvl > lo_lvl);
    else             hold_d = (cur_lvl >= hi_lvl);
  end

  assign irq_set  = armed_q && hold_d && !hold_q && rts_irq_en && enh_en;
  assign irq_drop = irq_clr || (armed_q && hold_q && !hold_d);
  assign rts_n    = armed_q ? hold_q : !rts_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      rts_irq <= 1'b0;
    end else begin
      start_q <= rts_start;
      armed_q <= armed_d;
      hold_q  <= hold_d;
      if (irq_set)       rts_irq <= 1'b1;
      else if (irq_drop) rts_irq <= 1'b0;
    end
  end

  p_release_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cur_lvl >= hi_lvl) |=> (rts_n || !armed_q));
  p_reassert_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cur_lvl <= lo_lvl) |=> (!rts_n || !armed_q));
  p_irq_on_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n) && armed_q && $past(armed_q && rts_irq_en && enh_en)) |-> rts_irq);
endmodule

// File: rtl/rx_rts_fifo.sv
module rx_rts_fifo #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic [LVL_W-1:0]  level,
  output logic              overrun,
  input  logic              stat_rd,
  input  logic [1:0]        trig_sel,
  input  logic              auto_rts_en,
  input  logic              rts_start,
  input  logic              rts_irq_en,
  input  logic              enh_en,
  input  logic              irq_clr,
  output logic              rts_n,
  output logic              rts_irq
);
  localparam int ENT_W = DATA_W + ERR_W;

  logic [ENT_W-1:0] head;

  rx_fifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .LVL_W(LVL_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_entry ({wr_err, wr_data}),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_entry (head),
    .level    (level),
    .stat_rd  (stat_rd),
    .overrun  (overrun)
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_err  = head[ENT_W-1:DATA_W];

  rts_flow_ctl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) flow_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (level),
    .trig_sel    (trig_sel),
    .auto_rts_en (auto_rts_en),
    .rts_start   (rts_start),
    .rts_irq_en  (rts_irq_en),
    .enh_en      (enh_en),
    .irq_clr     (irq_clr),
    .rts_n       (rts_n),
    .rts_irq     (rts_irq)
  );
endmodule

// File: tb/rx_rts_fifo_tb_top.sv
module rx_rts_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic       rd_ready = 1'b0, rd_valid;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [5:0] level;
  logic       overrun, stat_rd = 1'b0;
  logic [1:0] trig_sel = 2'd1;
  logic       auto_rts_en = 1'b0, rts_start = 1'b0, rts_irq_en = 1'b0, enh_en = 1'b0;
  logic       irq_clr = 1'b0, rts_n, rts_irq;

  int          errors = 0;
  int          checks = 0;
  logic [10:0] sb[$];
  logic [10:0] last_pop = '0;
  logic [7:0]  cnt = 8'h30;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_rts_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_err(wr_err), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .level(level), .overrun(overrun),
    .stat_rd(stat_rd), .trig_sel(trig_sel), .auto_rts_en(auto_rts_en),
    .rts_start(rts_start), .rts_irq_en(rts_irq_en), .enh_en(enh_en),
    .irq_clr(irq_clr), .rts_n(rts_n), .rts_irq(rts_irq)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: presents one character, records it in the scoreboard if accepted.
  task automatic push();
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = cnt;
    wr_err   = cnt[2:0] ^ 3'b101;
    if (wr_ready) sb.push_back({wr_err, wr_data});
    cnt++;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic fill_to(input int n);
    while (int'(level) < n) push();
  endtask

  task automatic drain_to(input int n);
    while (int'(level) > n) pop();
  endtask

  // Monitor: compares every taken head entry against the scoreboard.
  always @(negedge clk) begin
    #1;
    if (rd_ready && rd_valid) begin
      if (sb.size() == 0) chk_eq("R1 unexpected entry", 1, 0);
      else begin
        last_pop = sb.pop_front();
        chk_eq("R1 head data", int'(rd_data), int'(last_pop[7:0]));
        chk_eq("R1 head tags", int'(rd_err), int'(last_pop[10:8]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk_eq("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R2 reset state, R6 manual pin
    chk_eq("R2 reset level", int'(level), 0);
    chk_eq("R2 reset rd_valid", int'(rd_valid), 0);
    chk_eq("R2 reset wr_ready", int'(wr_ready), 1);
    chk_eq("R2 reset overrun", int'(overrun), 0);
    chk_eq("R6 reset rts_n", int'(rts_n), 1);
    chk_eq("R10 reset rts_irq", int'(rts_irq), 0);
    rts_start = 1'b1; idle();
    chk_eq("R6 manual low", int'(rts_n), 0);
    rts_start = 1'b0; idle();
    chk_eq("R6 manual high", int'(rts_n), 1);

    // R1/R2 ordering with tags
    for (int i = 0; i < 5; i++) push();
    chk_eq("R2 level after 5 writes", int'(level), 5);
    chk_eq("R1 rd_valid nonempty", int'(rd_valid), 1);
    drain_to(2);
    // R4 simultaneous read and write
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hA5; wr_err = 3'b011; rd_ready = 1'b1;
    sb.push_back({wr_err, wr_data});
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    chk_eq("R4 level unchanged", int'(level), 2);
    drain_to(0);
    // R5 empty read
    pop();
    chk_eq("R5 level stays 0", int'(level), 0);
    chk_eq("R5 last data held", int'(rd_data), int'(last_pop[7:0]));
    chk_eq("R5 last tags held", int'(rd_err), int'(last_pop[10:8]));

    // R7 no arming when start already set
    rts_irq_en = 1'b1; enh_en = 1'b1; trig_sel = 2'd1;
    rts_start = 1'b1; idle();
    auto_rts_en = 1'b1; idle();
    fill_to(24); idle(); idle();
    chk_eq("R7 not armed stays low", int'(rts_n), 0);
    chk_eq("R7 no irq when not armed", int'(rts_irq), 0);
    drain_to(0);
    rts_start = 1'b0; idle();
    chk_eq("R7 disarmed manual high", int'(rts_n), 1);
    rts_start = 1'b1; idle(); idle();
    chk_eq("R7 armed low", int'(rts_n), 0);

    // R8 release one step above trigger 16
    fill_to(16); idle();
    chk_eq("R8 low at programmed level", int'(rts_n), 0);
    fill_to(23); idle();
    chk_eq("R8 low at 23", int'(rts_n), 0);
    push(); idle();
    chk_eq("R8 released at 24", int'(rts_n), 1);
    chk_eq("R10 irq on release", int'(rts_irq), 1);
    // R9 hysteresis down to 8
    drain_to(15); idle();
    chk_eq("R9 still high at 15", int'(rts_n), 1);
    drain_to(9); idle();
    chk_eq("R9 still high at 9", int'(rts_n), 1);
    pop(); idle();
    chk_eq("R9 low at 8", int'(rts_n), 0);
    chk_eq("R10 irq cleared on reassert", int'(rts_irq), 0);

    // R12 accepts until full, R3 overrun
    fill_to(32);
    chk_eq("R12 filled to 32", int'(level), 32);
    chk_eq("R2 wr_ready low when full", int'(wr_ready), 0);
    push();
    chk_eq("R3 level held at full", int'(level), 32);
    chk_eq("R3 overrun set", int'(overrun), 1);
    idle();
    chk_eq("R3 overrun sticky", int'(overrun), 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk_eq("R3 overrun cleared", int'(overrun), 0);
    chk_eq("R10 irq set by refill", int'(rts_irq), 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk_eq("R10 irq cleared by host", int'(rts_irq), 0);
    chk_eq("R10 pin still high", int'(rts_n), 1);
    drain_to(0); idle();
    chk_eq("R9 low when empty", int'(rts_n), 0);

    // R11 code 3: release only at full
    trig_sel = 2'd3; idle();
    fill_to(31); idle();
    chk_eq("R11 low at 31", int'(rts_n), 0);
    push(); idle();
    chk_eq("R11 released at full", int'(rts_n), 1);
    drain_to(25); idle();
    chk_eq("R11 high at 25", int'(rts_n), 1);
    pop(); idle();
    chk_eq("R11 low at 24", int'(rts_n), 0);
    drain_to(0);
    // R11 code 0: reassert only when empty
    trig_sel = 2'd0; idle();
    fill_to(15); idle();
    chk_eq("R11 low at 15", int'(rts_n), 0);
    push(); idle();
    chk_eq("R11 released at 16", int'(rts_n), 1);
    drain_to(1); idle();
    chk_eq("R11 high at 1", int'(rts_n), 1);
    pop(); idle();
    chk_eq("R11 low at empty", int'(rts_n), 0);
    chk_eq("R1 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule